// File: doc/BRIEF.md
# Single-Precision Float Classifier

This block inspects one 32-bit IEEE-754 single-precision operand and reports which of ten value classes it falls in, as a one-hot mask placed in the low bits of an integer-register-wide result. All higher result bits are zero. The classes are the two infinities, negative and positive normals, negative and positive subnormals, the two signed zeros, signaling NaN and quiet NaN.

An operand is offered with a valid strobe. The mask and a matching valid strobe appear on the registered outputs one clock later. There is no backpressure, so a new operand may be offered on every cycle. The block raises no floating-point exception flags and has no flag output. The classify step is pure combinational decode of the exponent and fraction fields, followed by a single output register stage.

Top module: `fp_class_unit`

## Requirements
- R1: After reset, `res_vld` is 0 and `res_mask` is all zero.
- R2: `res_vld` equals the value `op_vld` had at the previous clock edge. `res_mask` is loaded only on cycles where `op_vld` is high, and otherwise holds its value.
- R3: For a valid operand, exactly one of mask bits 0..9 is set, and every result bit from 10 up to XLEN-1 is zero.
- R4: Bit 0 means negative infinity and bit 7 means positive infinity. An infinity has sign = bit 31, exponent bits 30:23 all ones and fraction bits 22:0 zero.
- R5: Bit 1 means a negative normal and bit 6 a positive normal. A normal has an exponent that is neither all zeros nor all ones.
- R6: Bit 2 means a negative subnormal and bit 5 a positive subnormal. A subnormal has an exponent of zero and a nonzero fraction.
- R7: Bit 3 means negative zero (0x80000000) and bit 4 means positive zero (0x00000000).
- R8: Bit 9 means a quiet NaN: exponent all ones and fraction bit 22 set.
- R9: Bit 8 means a signaling NaN: exponent all ones, fraction bit 22 clear and the rest of the fraction nonzero.
- R10: The sign bit of a NaN has no effect on its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_vld | input | 1 | Operand valid |
| op_bits | input | 32 | Single-precision operand |
| res_vld | output | 1 | Result valid, one cycle after op_vld |
| res_mask | output | XLEN | Class mask, zero-extended |

## Verification
Every result is due exactly one rising edge after its operand is presented. The bench drives the operand and strobe just after a falling edge. On each following falling edge it compares the outputs with a reference model, which keeps a one-entry queue of the expected mask and valid for the previous cycle. The model is also applied to idle cycles, so a mask that is held while `op_vld` is low is checked against the last valid result. Stimulus covers each class with both signs and the field boundaries: the largest subnormal, the smallest and largest normals, the lowest signaling NaN and the canonical quiet NaN.

// File: rtl/fp_class_pkg.sv
// Shared definitions for the float classifier: the widths of the IEEE-754
// single-precision fields and the bit position of each class in the mask.
package fp_class_pkg;
    localparam int SP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int NCLASS  = 10;

    // Position of each class in the one-hot mask; the order is architectural.
    localparam int C_NINF  = 0;
    localparam int C_NNORM = 1;
    localparam int C_NSUB  = 2;
    localparam int C_NZERO = 3;
    localparam int C_PZERO = 4;
    localparam int C_PSUB  = 5;
    localparam int C_PNORM = 6;
    localparam int C_PINF  = 7;
    localparam int C_SNAN  = 8;
    localparam int C_QNAN  = 9;

    // Summary of the exponent and fraction fields, independent of the sign.
    typedef struct packed {
        logic exp_zero;
        logic exp_ones;
        logic frac_zero;
        logic frac_msb;
    } fld_flags_t;
endpackage

// File: rtl/fp_field_decode.sv
// Splits an operand into its sign, exponent and fraction fields and reduces
// the exponent and fraction to a few flags. Purely combinational.
// Assumes the IEEE-754 single-precision layout described by fp_class_pkg.
module fp_field_decode
    import fp_class_pkg::*;
(
    input  logic [SP_W-1:0] val,
    output logic            sign,
    output fld_flags_t      flg
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    // Slice the operand into its fields and reduce them to flags.
    always_comb begin
        sign          = val[SP_W-1];
        expo          = val[SP_W-2 -: EXP_W];
        frac          = val[FRAC_W-1:0];
        flg.exp_zero  = (expo == '0);
        flg.exp_ones  = (expo == '1);
        flg.frac_zero = (frac == '0);
        flg.frac_msb  = frac[FRAC_W-1];
    end
endmodule

// File: rtl/fp_class_encode.sv
// Turns the sign and the field flags into a ten-bit one-hot class mask.
// Purely combinational. The class conditions are mutually exclusive by
// construction, so exactly one bit is set for any input.
module fp_class_encode
    import fp_class_pkg::*;
(
    input  logic              sign,
    input  fld_flags_t        flg,
    output logic [NCLASS-1:0] mask
);
    logic is_inf, is_nan, is_zero, is_sub, is_norm;

    // Pick the magnitude category from the exponent and fraction flags.
    always_comb begin
        is_inf  = flg.exp_ones &  flg.frac_zero;
        is_nan  = flg.exp_ones & ~flg.frac_zero;
        is_zero = flg.exp_zero &  flg.frac_zero;
        is_sub  = flg.exp_zero & ~flg.frac_zero;
        is_norm = ~flg.exp_zero & ~flg.exp_ones;
    end

    // Combine the category with the sign; a NaN ignores its sign.
    always_comb begin
        mask          = '0;
        mask[C_NINF]  = sign  & is_inf;
        mask[C_NNORM] = sign  & is_norm;
        mask[C_NSUB]  = sign  & is_sub;
        mask[C_NZERO] = sign  & is_zero;
        mask[C_PZERO] = ~sign & is_zero;
        mask[C_PSUB]  = ~sign & is_sub;
        mask[C_PNORM] = ~sign & is_norm;
        mask[C_PINF]  = ~sign & is_inf;
        mask[C_SNAN]  = is_nan & ~flg.frac_msb;
        mask[C_QNAN]  = is_nan &  flg.frac_msb;
    end
endmodule

// File: rtl/fp_class_unit.sv
// Top of the single-precision classifier. It decodes the operand, encodes
// the ten-bit class mask and registers it, zero-extended to XLEN, together
// with a valid strobe. Latency is one cycle; there is no backpressure.
// Assumes XLEN is at least the width of the class mask.
module fp_class_unit
    import fp_class_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_vld,
    input  logic [SP_W-1:0]     op_bits,
    output logic                res_vld,
    output logic [XLEN-1:0]     res_mask
);
    localparam int PAD_W = XLEN - NCLASS;

    logic              sgn;
    fld_flags_t        flags;
    logic [NCLASS-1:0] cls;
    logic [NCLASS-1:0] cls_q;

    fp_field_decode u_dec (
        .val  (op_bits),
        .sign (sgn),
        .flg  (flags)
    );

    fp_class_encode u_enc (
        .sign (sgn),
        .flg  (flags),
        .mask (cls)
    );

    // Register the strobe every cycle and the mask only on valid operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            cls_q   <= '0;
        end else begin
            res_vld <= op_vld;
            if (op_vld) cls_q <= cls;
        end
    end

    // Widen the mask; the upper bits are constant zero.
    generate
        if (PAD_W > 0) begin : g_pad
            assign res_mask = {{PAD_W{1'b0}}, cls_q};
        end else begin : g_nopad
            assign res_mask = cls_q;
        end
    endgenerate
endmodule

// File: rtl/fp_class_unit_chk.sv
// Checker for fp_class_unit, attached by bind. It watches the ports only.
module fp_class_unit_chk
    import fp_class_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_vld,
    input logic [SP_W-1:0] op_bits,
    input logic            res_vld,
    input logic [XLEN-1:0] res_mask
);
    logic past_ok;

    // Marks that at least one clock edge has followed the end of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: the outputs are cleared in the cycle after reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && res_mask == '0));

    // R2: the result strobe follows the operand strobe one cycle later.
    a_r2_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (res_vld == $past(op_vld)));

    // R2: the mask holds when no operand was presented.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !op_vld) |=> $stable(res_mask));

    // R3: a valid result is one-hot in bits 0..9 with nothing above them.
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> ($countones(res_mask[NCLASS-1:0]) == 1
                     && (res_mask >> NCLASS) == '0));

    // R7: a positive zero operand yields the positive-zero class.
    a_r7_pzero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_bits == 32'h0000_0000) |=> res_mask[C_PZERO]);

    // R8: an exponent of all ones with the fraction MSB set is a quiet NaN.
    a_r8_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_bits[30:22] == 9'h1FF) |=> res_mask[C_QNAN]);

    // R10: a NaN never lands in a signed class.
    a_r10_nan_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_bits[30:23] == 8'hFF && op_bits[22:0] != '0)
        |=> (res_mask[7:0] == '0));
endmodule

bind fp_class_unit fp_class_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_vld   (op_vld),
    .op_bits  (op_bits),
    .res_vld  (res_vld),
    .res_mask (res_mask)
);

// File: tb/fp_class_unit_test.sv
module fp_class_unit_test;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_vld = 1'b0;
    logic [31:0]     op_bits = '0;
    logic            res_vld;
    logic [XLEN-1:0] res_mask;

    int total = 0;
    int bad = 0;

    // Reference state: expectation for the next compare.
    logic [XLEN-1:0] exp_mask = '0;
    logic            exp_vld = 1'b0;
    logic [XLEN-1:0] q_mask[$];
    logic            q_vld[$];
    string           q_tag[$];
    string           exp_tag = "R1";

    always #2.5 clk = ~clk;

    fp_class_unit #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_bits(op_bits),
        .res_vld(res_vld), .res_mask(res_mask)
    );

    // Behavioural model of the classes, written from the requirements.
    function automatic logic [XLEN-1:0] model(input logic [31:0] v);
        int e = int'(v[30:23]);
        int f = int'(v[22:0]);
        int idx;
        if (e == 255 && f != 0)      idx = v[22] ? 9 : 8;        // R8 R9 R10
        else if (e == 255)           idx = v[31] ? 0 : 7;        // R4
        else if (e == 0 && f == 0)   idx = v[31] ? 3 : 4;        // R7
        else if (e == 0)             idx = v[31] ? 2 : 5;        // R6
        else                         idx = v[31] ? 1 : 6;        // R5
        model = '0;
        model[idx] = 1'b1;
    endfunction

    task automatic check(input string tag);
        total++;
        if (res_vld !== exp_vld || res_mask !== exp_mask) begin
            bad++;
            $display("FAIL %s: got vld=%0b mask=%h expected vld=%0b mask=%h",
                     tag, res_vld, res_mask, exp_vld, exp_mask);
        end
    endtask

    // Present one operand (or an idle cycle) and queue its expected result.
    task automatic drive(input logic v, input logic [31:0] bits, input string tag);
        logic [XLEN-1:0] m;
        op_vld  = v;
        op_bits = bits;
        m = v ? model(bits) : (q_mask.size() > 0 ? q_mask[$] : exp_mask);
        q_mask.push_back(m);
        q_vld.push_back(v);
        q_tag.push_back(tag);
        @(negedge clk);
        exp_mask = q_mask.pop_front();
        exp_vld  = q_vld.pop_front();
        exp_tag  = q_tag.pop_front();
        check(exp_tag);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: got running expected finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_vld = 1'b0; exp_mask = '0;
        check("R1");
        rst_n = 1'b1;
        drive(1, 32'hFF80_0000, "R4 neg inf");
        drive(1, 32'h7F80_0000, "R4 pos inf");
        drive(1, 32'hBF80_0000, "R5 neg normal");
        drive(1, 32'h0080_0000, "R5 smallest pos normal");
        drive(1, 32'h7F7F_FFFF, "R5 largest pos normal");
        drive(1, 32'h807F_FFFF, "R6 neg largest subnormal");
        drive(1, 32'h0000_0001, "R6 pos smallest subnormal");
        drive(1, 32'h8000_0000, "R7 neg zero");
        drive(1, 32'h0000_0000, "R7 pos zero");
        drive(1, 32'h7FC0_0000, "R8 quiet NaN");
        drive(1, 32'hFFC0_0001, "R8 R10 neg quiet NaN");
        drive(1, 32'h7F80_0001, "R9 lowest signaling NaN");
        drive(1, 32'hFFBF_FFFF, "R9 R10 neg signaling NaN");
        drive(0, 32'h0000_0000, "R2 idle hold");
        drive(0, 32'h7F80_0000, "R2 idle ignores operand");
        drive(1, 32'h4049_0FDB, "R3 pos normal upper zero");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom();
            if (i % 4 == 0) r[30:23] = 8'hFF;
            if (i % 4 == 1) r[30:23] = 8'h00;
            drive((i % 5) != 0, r, "R3 sweep");
        end
        drive(0, 32'h0, "R2 drain");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule